// File: doc/BRIEF.md
# Scan Chain Test Wrapper

This block places a small synchronous state machine inside a scan wrapper. The flip-flops of the wrapped machine hold its state and its registered primary input. Each of them is fed by a two-way selector. One leg takes the functional next value and the other takes the neighbouring flip-flop, so the same flops form a serial shift path from `scan_in` to `scan_out`. A primary input registered this way reaches the next-state logic in step with the clock, and it can be set through the chain like any state bit.

With `test_mode` low the wrapper runs functionally on every clock. With `test_mode` high the wrapper holds its state until a built-in sequencer receives `start`. The sequencer then applies one test vector in three phases. First it shifts the pattern in, one bit per clock. Next it runs exactly one functional clock, capturing the next state and sampling the primary output. Last it shifts the captured chain out, assembles it on a parallel result port and pulses `done`. While the captured bits leave, the next vector can enter. If `start` is high on the last unload clock, the sequencer goes straight to the next capture.

The sequencer has four states:
- `SQ_IDLE`: waiting.
- `SQ_LOAD`: first shift-in.
- `SQ_CAPTURE`: the single functional clock.
- `SQ_UNLOAD`: shift-out overlapped with the next shift-in.

Its transitions are:
- IDLE→LOAD on `test_mode && start`.
- LOAD→CAPTURE after CHAIN_W shifts.
- CAPTURE→UNLOAD always.
- UNLOAD→CAPTURE after CHAIN_W shifts when `start` is high.
- UNLOAD→IDLE after CHAIN_W shifts when `start` is low.
- Any busy state→IDLE when `test_mode` is low.

Top module: `scan_wrap`

## Requirements
- R1: A synchronous reset clears every chain flop, `result`, `done` and `cap_out`, and returns the sequencer to idle with `busy` low.
- R2: With `test_mode` low, `shift_en` stays low and the chain advances on every clock. Bit 0 takes `func_in`. The state s = chain[CHAIN_W-1:1] becomes {s[STATE_W-2:0], s[STATE_W-1] ^ chain[0]}. `func_out` is the XOR of all chain bits.
- R3: Chain order is fixed. Bit 0 is the input register and bits CHAIN_W-1..1 hold the state (CHAIN_W = STATE_W+1). While shifting, `scan_in` enters bit 0, bit i moves to bit i+1, and `scan_out` always shows bit CHAIN_W-1. A vector V therefore loads MSB first.
- R4: When the sequencer is idle, `test_mode` is high and `start` is high, `shift_en` goes high for exactly CHAIN_W consecutive clocks.
- R5: After loading, exactly one clock runs with `shift_en` low. On that clock the chain takes its functional next value, and bit 0 captures `func_in`.
- R6: `cap_out` holds the value `func_out` had during the capture clock. That output is sampled directly and is not sent through the chain.
- R7: After capture the chain shifts CHAIN_W clocks. `done` then pulses for one clock, with `result` equal to the captured chain (bit i = chain bit i).
- R8: If `start` is high on the last unload clock, the bits shifted in during unload become the next vector and the next clock is a capture. The sequencer does not shift in again first.
- R9: `start` has no effect while `test_mode` is low. Dropping `test_mode` during a test returns the sequencer to idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| test_mode | input | 1 | 1 = sequencer owns the chain, 0 = functional operation |
| start | input | 1 | Begin a test vector, or continue with the next one on the last unload clock |
| func_in | input | 1 | Primary input of the wrapped machine |
| scan_in | input | 1 | Serial chain input |
| scan_out | output | 1 | Serial chain output (chain MSB) |
| func_out | output | 1 | Primary output of the wrapped machine |
| shift_en | output | 1 | Mode select: 1 shift, 0 normal |
| busy | output | 1 | Sequencer not idle |
| done | output | 1 | One-clock pulse when `result` is complete |
| cap_out | output | 1 | Primary output sampled on the capture clock |
| result | output | STATE_W+1 | Captured chain assembled from `scan_out` |

## Verification
The assertions check the following on every cycle:
- shift moves of the chain;
- the exact CHAIN_W-clock length of each shift window, checked with a counter;
- the single-cycle capture and `done` pulses;
- `cap_out` sampling;
- idle holding;
- that shifting and capturing never occur in functional mode.

Other behaviour can only be shown by the bench's scenarios. These include the actual captured values for given vectors, the MSB-first load order, the overlapped next vector, the functional next-state sequence and the visible effect of reset mid-test.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_LOAD    = 2'd1,
        SQ_CAPTURE = 2'd2,
        SQ_UNLOAD  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/scan_cell.sv
module scan_cell (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic sel_shift,
    input  logic d_func,
    input  logic d_scan,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else if (en) begin
            q <= sel_shift ? d_scan : d_func;
        end
    end

endmodule

// File: rtl/cut_logic.sv
module cut_logic #(
    parameter int STATE_W = 3
) (
    input  logic [STATE_W-1:0] cur_state,
    input  logic               in_bit,
    output logic [STATE_W-1:0] next_state,
    output logic               out_bit
);

    always_comb begin
        next_state = {cur_state[STATE_W-2:0], cur_state[STATE_W-1] ^ in_bit};
        out_bit    = (^cur_state) ^ in_bit;
    end

endmodule

// File: rtl/scan_seq.sv
module scan_seq
    import scan_pkg::*;
#(
    parameter int CHAIN_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               test_mode,
    input  logic               start,
    input  logic               chain_msb,
    output logic               shift_en,
    output logic               capture,
    output logic               cell_en,
    output logic               busy,
    output logic               done,
    output logic [CHAIN_W-1:0] result
);

    localparam int CNT_W = (CHAIN_W > 2) ? $clog2(CHAIN_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CHAIN_W - 1);

    seq_state_t       st, nxt;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last = (cnt == LAST);

    always_comb begin
        nxt = st;
        unique case (st)
            SQ_IDLE:    if (test_mode && start) nxt = SQ_LOAD;
            SQ_LOAD:    if (!test_mode) nxt = SQ_IDLE;
                        else if (last) nxt = SQ_CAPTURE;
            SQ_CAPTURE: nxt = test_mode ? SQ_UNLOAD : SQ_IDLE;
            SQ_UNLOAD:  if (!test_mode) nxt = SQ_IDLE;
                        else if (last) nxt = start ? SQ_CAPTURE : SQ_IDLE;
            default:    nxt = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            st  <= nxt;
            cnt <= (nxt != st) ? '0 : cnt + 1'b1;
        end
    end

    always_comb begin
        shift_en = test_mode && ((st == SQ_LOAD) || (st == SQ_UNLOAD));
        capture  = test_mode && (st == SQ_CAPTURE);
        busy     = (st != SQ_IDLE);
        cell_en  = !test_mode || shift_en || capture;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done   <= 1'b0;
            result <= '0;
        end else begin
            done <= test_mode && (st == SQ_UNLOAD) && last;
            if (shift_en && (st == SQ_UNLOAD)) begin
                result <= {result[CHAIN_W-2:0], chain_msb};
            end
        end
    end

    logic [CNT_W+1:0] run_len;
    always_ff @(posedge clk) begin
        if (rst) run_len <= '0;
        else     run_len <= shift_en ? run_len + 1'b1 : '0;
    end

    a_r4_shift_len: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && test_mode && run_len != 0) |-> (run_len == (CNT_W+2)'(CHAIN_W)));
    a_r5_one_capture: assert property (@(posedge clk) disable iff (rst)
        capture |=> !capture);
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (st == SQ_IDLE && !done && result == '0));
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (st == SQ_IDLE && !(test_mode && start)) |=> (st == SQ_IDLE));
    a_r2_no_test_in_func: assert property (@(posedge clk) disable iff (rst)
        !test_mode |-> (!shift_en && !capture));

endmodule

// File: rtl/scan_wrap.sv
module scan_wrap #(
    parameter int STATE_W = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               test_mode,
    input  logic               start,
    input  logic               func_in,
    input  logic               scan_in,
    output logic               scan_out,
    output logic               func_out,
    output logic               shift_en,
    output logic               busy,
    output logic               done,
    output logic               cap_out,
    output logic [STATE_W:0]   result
);

    localparam int CHAIN_W = STATE_W + 1;

    logic [CHAIN_W-1:0] chain, d_func, d_scan;
    logic [STATE_W-1:0] ns_state;
    logic               capture, cell_en;

    cut_logic #(.STATE_W(STATE_W)) u_cut (
        .cur_state  (chain[CHAIN_W-1:1]),
        .in_bit     (chain[0]),
        .next_state (ns_state),
        .out_bit    (func_out)
    );

    scan_seq #(.CHAIN_W(CHAIN_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .test_mode (test_mode),
        .start     (start),
        .chain_msb (chain[CHAIN_W-1]),
        .shift_en  (shift_en),
        .capture   (capture),
        .cell_en   (cell_en),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    assign d_func = {ns_state, func_in};
    assign d_scan = {chain[CHAIN_W-2:0], scan_in};

    for (genvar i = 0; i < CHAIN_W; i++) begin : g_cell
        scan_cell u_cell (
            .clk       (clk),
            .rst       (rst),
            .en        (cell_en),
            .sel_shift (shift_en),
            .d_func    (d_func[i]),
            .d_scan    (d_scan[i]),
            .q         (chain[i])
        );
    end

    assign scan_out = chain[CHAIN_W-1];

    always_ff @(posedge clk) begin
        if (rst)          cap_out <= 1'b0;
        else if (capture) cap_out <= func_out;
    end

    a_r3_shift_entry: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (chain[0] == $past(scan_in)));
    a_r3_shift_move: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (chain[CHAIN_W-1:1] == $past(chain[CHAIN_W-2:0])));
    a_r6_cap_sample: assert property (@(posedge clk) disable iff (rst)
        capture |=> (cap_out == $past(func_out)));
    a_r5_capture_input: assert property (@(posedge clk) disable iff (rst)
        capture |=> (chain[0] == $past(func_in)));
    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (test_mode && !busy && !start) |=> $stable(chain));

endmodule

// File: tb/scan_wrap_tb.sv
`timescale 1ns/1ps
module scan_wrap_tb;

    localparam int SW = 3;
    localparam int CW = SW + 1;
    localparam int NV = 6;

    // columns: loaded vector, func_in at capture, expected captured chain, expected cap_out
    localparam logic [CW-1:0] VEC  [NV] = '{4'b0000, 4'b0010, 4'b1001, 4'b1000, 4'b1111, 4'b0111};
    localparam logic          FI   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [CW-1:0] CAPT [NV] = '{4'b0000, 4'b0101, 4'b0000, 4'b0011, 4'b1101, 4'b1110};
    localparam logic          PO   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    logic clk = 1'b0, rst = 1'b1, test_mode = 1'b0, start = 1'b0, func_in = 1'b0, scan_in = 1'b0;
    logic scan_out, func_out, shift_en, busy, done, cap_out;
    logic [CW-1:0] result;
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    scan_wrap #(.STATE_W(SW)) u_dut (
        .clk(clk), .rst(rst), .test_mode(test_mode), .start(start),
        .func_in(func_in), .scan_in(scan_in), .scan_out(scan_out),
        .func_out(func_out), .shift_en(shift_en), .busy(busy), .done(done),
        .cap_out(cap_out), .result(result)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // from idle: start and shift V in MSB first (R3, R4)
    task automatic load_vec(input logic [CW-1:0] v);
        int hi = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = CW - 1; i >= 0; i--) begin
            if (shift_en) hi++;
            scan_in = v[i];
            @(negedge clk);
        end
        check("R4 shift window length", hi, CW);
    endtask

    // entry in capture state; exit after done (in capture if cont)
    task automatic finish_vec(input logic fi, input logic [CW-1:0] exp_c, input logic exp_po,
                              input logic [CW-1:0] nxt, input logic cont);
        check("R5 single normal clock", shift_en, 1'b0);
        check("R6 func_out before capture", func_out, exp_po);
        func_in = fi;
        @(negedge clk);
        check("R6 cap_out", cap_out, exp_po);
        check("R5 captured msb on scan_out", scan_out, exp_c[CW-1]);
        for (int j = CW - 1; j >= 0; j--) begin
            scan_in = nxt[j];
            if (j == 0 && cont) start = 1'b1;
            @(negedge clk);
        end
        start = 1'b0;
        check("R7 done pulse", done, 1'b1);
        check("R7 result", result, exp_c);
        if (!cont) begin
            @(negedge clk);
            check("R7 done one cycle", done, 1'b0);
            check("R7 back to idle", busy, 1'b0);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [CW-1:0] m;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 busy", busy, 1'b0);
        check("R1 done", done, 1'b0);
        check("R1 result", result, '0);
        check("R1 cap_out", cap_out, 1'b0);
        check("R1 scan_out", scan_out, 1'b0);

        // R2 functional mode with model
        m = '0;
        for (int k = 0; k < 10; k++) begin
            func_in = ((k * 7 + 3) % 5) > 1;
            @(negedge clk);
            m = {m[CW-2:1], m[CW-1] ^ m[0], func_in};
            check("R2 shift_en low", shift_en, 1'b0);
            check("R2 func_out", func_out, ^m);
            check("R3 scan_out msb", scan_out, m[CW-1]);
        end

        // R9 start ignored when test_mode low
        start = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b0;
        check("R9 no start in func mode", busy, 1'b0);
        check("R9 no shift in func mode", shift_en, 1'b0);

        // table walk
        test_mode = 1'b1;
        @(negedge clk);
        for (int v = 0; v < NV; v++) begin
            load_vec(VEC[v]);
            finish_vec(FI[v], CAPT[v], PO[v], '0, 1'b0);
        end

        // R8 overlapped next vector
        load_vec(VEC[1]);
        finish_vec(FI[1], CAPT[1], PO[1], VEC[4], 1'b1);
        check("R8 straight to capture", busy && !shift_en, 1'b1);
        finish_vec(FI[4], CAPT[4], PO[4], '0, 1'b0);

        // R9 abort by dropping test_mode
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scan_in = 1'b1;
        @(negedge clk);
        test_mode = 1'b0;
        @(negedge clk);
        check("R9 abort to idle", busy, 1'b0);
        test_mode = 1'b1;
        @(negedge clk);

        // R1 reset mid-test
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        scan_in = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 idle after mid reset", busy, 1'b0);
        check("R1 chain cleared", scan_out, 1'b0);
        check("R1 func_out cleared", func_out, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule